// File: doc/BRIEF.md
# Stochastic Leaky Integrate-and-Fire Neuron

This block is a clocked digital model of one spiking neuron. A signed membrane register collects synaptic weights presented on a valid-qualified input. A programmable leak pulls a positive membrane back toward zero every cycle. A pseudo-random walk nudges the membrane up or down by a fixed step at a programmable interval. Because of the walk, the chance that the neuron fires grows with how close the membrane sits to the threshold.

In each cycle the block first adds the incoming weight, then applies the leak, then applies the walk, and saturates the result. It compares that result against a signed threshold. When the membrane goes above the threshold, the block emits a spike and clears the membrane. It then discards input for a programmable number of refractory cycles. Every neuron runs on its own, so a spike depends only on this neuron's own history. The membrane value is visible on a port for debug.

Top module: `stoch_lif_neuron`

## Requirements
- R1: While rst_ni is low, membrane_o reads 0 and spike_o reads 0. The random-walk cycle counter clears to 0 and the direction generator loads the seed 16'hACE1.
- R2: Outside refractory, a cycle with in_valid_i high adds the sign-extended two's-complement in_weight_i to the membrane. A cycle with in_valid_i low adds nothing.
- R3: Outside refractory, after the weight is added, a positive membrane is lowered by the unsigned leak_i. The leak never takes the membrane below 0. A membrane at or below 0 is not changed by the leak.
- R4: The membrane is compared, as a signed value, against threshold_i after the weight, the leak and the walk of that cycle have been applied. If it is strictly greater, spike_o is high for the following cycle and membrane_o reads 0. A value equal to the threshold does not fire.
- R5: After a spike, for the next refr_len_i cycles, in_valid_i and in_weight_i are discarded. During those cycles no leak or walk is applied, membrane_o stays 0 and spike_o stays low. A refr_len_i of 0 gives no refractory interval.
- R6: The membrane saturates at the most positive and most negative values of its signed width instead of wrapping.
- R7: A cycle counter ticks the walk on every cycle whose count has reached walk_period_i, so the walk runs once every walk_period_i+1 cycles after reset. On each tick, walk_step_i is added when bit 0 of the direction generator is 1 and subtracted when it is 0. The generator then shifts left, taking in bit15^bit13^bit12^bit10 as its new bit 0. The generator advances on every tick, including ticks inside refractory. A walk_step_i of 0 disables the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Qualifies in_weight_i for this cycle |
| in_weight_i | input | W_W (8) | Signed synaptic weight |
| threshold_i | input | MEM_W (16) | Signed firing threshold |
| leak_i | input | MEM_W (16) | Unsigned leak amount per cycle |
| walk_step_i | input | MEM_W (16) | Unsigned random-walk step |
| walk_period_i | input | PER_W (8) | Walk runs every walk_period_i+1 cycles |
| refr_len_i | input | REF_W (8) | Refractory length in cycles |
| spike_o | output | 1 | One-cycle spike |
| membrane_o | output | MEM_W (16) | Signed membrane value (debug) |

## Verification
The bench checks a membrane that lands exactly on the threshold and one that lands just above it. A comparison that fires on equality would spike one vector too early. It drives inhibitory weights together with a leak, where a design that also leaks negative values, or that leaks below zero, would drift away from the expected membrane. It hammers both saturation limits, which catches a wrapping adder because the sign would flip. It sends full-scale weights during refractory, which would cause an instant refire if the design buffered or accepted them. Finally, it follows the walk against an independent model of the tick counter and the direction generator, which exposes a wrong period, a wrong tap set or a reversed direction.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic {WALK_DN = 1'b0, WALK_UP = 1'b1} walk_dir_e;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/lif_lfsr.sv
module lif_lfsr
  import lif_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      adv_i,
  output walk_dir_e dir_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= LFSR_SEED;
    else if (adv_i) state_q <= lfsr_next(state_q);
  end

  assign dir_o = walk_dir_e'(state_q[0]);

  // R7: maximal-length sequence never reaches the all-zero lockup state
  a_r7_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/lif_walk_gen.sv
module lif_walk_gen
  import lif_pkg::*;
#(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o,
  output walk_dir_e        dir_o
);
  logic [PER_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  lif_lfsr i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (tick_o),
    .dir_o  (dir_o)
  );

  // R7: counter restarts after every tick
  a_r7_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/lif_refractory.sv
module lif_refractory #(
  parameter int unsigned REF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [REF_W-1:0] len_i,
  output logic             busy_o
);
  logic [REF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R5: no new fire request can be raised while the interval is running
  a_r5_no_fire_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !fire_i);
endmodule

// File: rtl/lif_membrane.sv
module lif_membrane
  import lif_pkg::*;
#(
  parameter int unsigned W_W   = 8,
  parameter int unsigned MEM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [W_W-1:0]   weight_i,
  input  logic [MEM_W-1:0] thr_i,
  input  logic [MEM_W-1:0] leak_i,
  input  logic [MEM_W-1:0] step_i,
  input  logic             tick_i,
  input  walk_dir_e        dir_i,
  input  logic             busy_i,
  output logic             fire_o,
  output logic             spike_o,
  output logic [MEM_W-1:0] mem_o
);
  localparam int unsigned EXT = MEM_W + 2;
  localparam logic signed [EXT-1:0] MAX_V = $signed({3'b000, {(MEM_W-1){1'b1}}});
  localparam logic signed [EXT-1:0] MIN_V = $signed({3'b111, {(MEM_W-1){1'b0}}});

  logic signed [MEM_W-1:0] mem_q;
  logic signed [EXT-1:0]   s_in, s_leak, s_walk, s_sat, w_ext, leak_ext, step_ext, thr_ext;
  logic                    spike_q;

  always_comb begin
    w_ext    = $signed({{(EXT-W_W){weight_i[W_W-1]}}, weight_i});
    leak_ext = $signed({2'b00, leak_i});
    step_ext = $signed({2'b00, step_i});
    thr_ext  = $signed({{2{thr_i[MEM_W-1]}}, thr_i});

    s_in = $signed({{2{mem_q[MEM_W-1]}}, mem_q});
    if (valid_i) s_in = s_in + w_ext;

    // leak pulls toward zero but never past it
    if (s_in > 0) s_leak = (s_in > leak_ext) ? s_in - leak_ext : '0;
    else          s_leak = s_in;

    s_walk = s_leak;
    if (tick_i) s_walk = (dir_i == WALK_UP) ? s_leak + step_ext : s_leak - step_ext;

    if (s_walk > MAX_V)      s_sat = MAX_V;
    else if (s_walk < MIN_V) s_sat = MIN_V;
    else                     s_sat = s_walk;

    fire_o = !busy_i && (s_sat > thr_ext);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= '0;
      spike_q <= 1'b0;
    end else begin
      spike_q <= fire_o;
      if (busy_i || fire_o) mem_q <= '0;
      else                  mem_q <= s_sat[MEM_W-1:0];
    end
  end

  assign spike_o = spike_q;
  assign mem_o   = mem_q;

  // R4: a spike is always accompanied by a cleared membrane
  a_r4_spike_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_q |-> (mem_q == '0));
  // R5: membrane held at zero and silent during refractory
  a_r5_refr_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (mem_q == '0) && !spike_q);
  // R3: with no input and no walk, the leak cannot push a nonnegative membrane negative
  a_r3_leak_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !tick_i && !mem_q[MEM_W-1]) |=> !mem_q[MEM_W-1]);
  // R6: with no walk, a positive weight on a nonnegative membrane never produces a negative one
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !weight_i[W_W-1] && !tick_i && !busy_i && !mem_q[MEM_W-1]) |=> !mem_q[MEM_W-1]);
endmodule

// File: rtl/stoch_lif_neuron.sv
module stoch_lif_neuron
  import lif_pkg::*;
#(
  parameter int unsigned W_W   = 8,
  parameter int unsigned MEM_W = 16,
  parameter int unsigned PER_W = 8,
  parameter int unsigned REF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [W_W-1:0]   in_weight_i,
  input  logic [MEM_W-1:0] threshold_i,
  input  logic [MEM_W-1:0] leak_i,
  input  logic [MEM_W-1:0] walk_step_i,
  input  logic [PER_W-1:0] walk_period_i,
  input  logic [REF_W-1:0] refr_len_i,
  output logic             spike_o,
  output logic [MEM_W-1:0] membrane_o
);
  logic      tick, busy, fire;
  walk_dir_e dir;

  lif_walk_gen #(.PER_W(PER_W)) i_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (walk_period_i),
    .tick_o   (tick),
    .dir_o    (dir)
  );

  lif_refractory #(.REF_W(REF_W)) i_refr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .len_i  (refr_len_i),
    .busy_o (busy)
  );

  lif_membrane #(.W_W(W_W), .MEM_W(MEM_W)) i_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .weight_i (in_weight_i),
    .thr_i    (threshold_i),
    .leak_i   (leak_i),
    .step_i   (walk_step_i),
    .tick_i   (tick),
    .dir_i    (dir),
    .busy_i   (busy),
    .fire_o   (fire),
    .spike_o  (spike_o),
    .mem_o    (membrane_o)
  );

  // R4: spike output never lasts more than one cycle while refractory is configured
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spike_o && (refr_len_i != '0)) |=> !spike_o);
endmodule

// File: tb/test_stoch_lif_neuron.sv
module test_stoch_lif_neuron;
  localparam int CLK_P = 10;
  localparam int NV = 10;
  localparam bit VV [NV] = '{1, 1, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam int VW [NV] = '{50, 30, 0, -99, 127, 3, 127, 127, 1, 103};
  localparam int VM [NV] = '{48, 76, 74, -25, 100, 0, 0, 0, 0, 0};
  localparam bit VS [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 1};

  logic        clk = 0, rst_ni = 0, in_valid = 0;
  logic [7:0]  in_weight = '0, walk_period = '0, refr_len = '0;
  logic [15:0] threshold = '0, leak = '0, walk_step = '0;
  logic        spike;
  logic [15:0] membrane;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  stoch_lif_neuron i_stoch_lif_neuron (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_weight_i(in_weight),
    .threshold_i(threshold), .leak_i(leak), .walk_step_i(walk_step),
    .walk_period_i(walk_period), .refr_len_i(refr_len),
    .spike_o(spike), .membrane_o(membrane));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0;
    #1;
    check("R1 membrane", int'($signed(membrane)), 0);
    check("R1 spike", int'(spike), 0);
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
  endtask

  task automatic step(input bit v, input int w);
    in_valid = v;
    in_weight = 8'(w);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // vector table: R2 accumulate, R3 leak, R4 threshold/equality, R5 refractory
    threshold = 16'd100; leak = 16'd2; walk_step = '0; walk_period = '0; refr_len = 8'd2;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VV[i], VW[i]);
      check($sformatf("R2/R3/R4/R5 vec%0d membrane", i), int'($signed(membrane)), VM[i]);
      check($sformatf("R4/R5 vec%0d spike", i), int'(spike), int'(VS[i]));
    end

    // R5: zero refractory accepts input right after a spike
    threshold = 16'd10; leak = '0; refr_len = '0;
    do_reset();
    step(1, 11);
    check("R4 spike on 11>10", int'(spike), 1);
    step(1, 5);
    check("R5 no refractory membrane", int'($signed(membrane)), 5);
    check("R4 spike one cycle", int'(spike), 0);
    // R1: async reset clears a built-up membrane
    do_reset();

    // R6: positive saturation
    threshold = 16'h7FFF;
    do_reset();
    for (int i = 0; i < 300; i++) step(1, 127);
    check("R6 positive saturation", int'($signed(membrane)), 32767);
    check("R6 no spike at max", int'(spike), 0);
    // R6: negative saturation
    do_reset();
    for (int i = 0; i < 300; i++) step(1, -128);
    check("R6 negative saturation", int'($signed(membrane)), -32768);
    // R3: leak leaves negative membrane untouched
    leak = 16'd50;
    step(0, 0);
    check("R3 no leak below zero", int'($signed(membrane)), -32768);
    leak = '0;

    // R7: random walk against independent model
    walk_step = 16'd3; walk_period = 8'd2;
    do_reset();
    begin
      logic [15:0] lf;
      int cnt, exp_m;
      lf = 16'hACE1; cnt = 0; exp_m = 0;
      for (int k = 0; k < 30; k++) begin
        step(0, 0);
        if (cnt >= 2) begin
          exp_m += lf[0] ? 3 : -3;
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          cnt = 0;
        end else cnt++;
        check($sformatf("R7 walk cycle %0d", k), int'($signed(membrane)), exp_m);
      end
    end
    // R7: step of zero disables the walk
    walk_step = '0;
    do_reset();
    for (int k = 0; k < 9; k++) step(0, 0);
    check("R7 zero step", int'($signed(membrane)), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule